// File: doc/BRIEF.md
# Serial DAC Register Interface

This block is the digital front end of an 18-bit serial digital-to-analog converter. A host talks to it over a three-wire serial link: a frame strobe (`sync_n`, active low), a serial clock (`sclk`) and a data line (`sdin`). Each frame carries a read flag, a register address and a data field. Three registers sit behind the link: the DAC value, a control word and a clear code. A fourth address takes write-only commands: a software clear and a software reset. The block drives the 18-bit code for the converter core and a one-cycle strobe whenever that code is loaded.

The serial pins are sampled by the block clock `clk`, so they must be synchronous to it and must stay stable for at least two `clk` cycles per level. Data is taken on the falling edge of `sclk`. `sdo` passes the previous contents of the frame shift register on, so several devices can be chained. It also returns the register named by a read frame during the following frame. Output loading is controlled by `ldac_n`: it happens at the end of the frame, or later on an `ldac_n` falling edge. `clr_n` loads the clear code into the DAC register and the output. `dev_reset_n` restores the power-on state. The core-side update strobe is held off until software releases the output clamp.

Top module: `sdac_port`

## Requirements
- R1: A frame is 24 bits, MSB first, taken on falling `sclk` edges while `sync_n` is low, and acted on when `sync_n` rises. Bit 23 is the read flag (1 = read). Bits 22:20 are the address: 1 = DAC, 2 = control, 3 = clear code, 4 = software command. Bits 19:0 are data. DAC and clear-code values sit in bits 19:2. With more than 24 edges, the last 24 bits form the frame.
- R2: A frame that ends after fewer than 24 falling `sclk` edges changes no register and no output.
- R3: `sdo` shows bit 23 of the frame shift register, so during a frame it shifts out the previous frame's 24 bits, MSB first. The bit is valid before each falling `sclk` edge. After reset it shifts out zeros.
- R4: A read frame makes the next frame shift out {1, address, data} on `sdo`. The data is value<<2 for the DAC and clear registers, the control word in bits 2:0 for address 2, and zero for other addresses.
- R5: A DAC write whose frame ends while `ldac_n` is low loads the output code at once. If `ldac_n` is high, the output holds until `ldac_n` falls, and then loads from the DAC register.
- R6: A falling edge on `clr_n` copies the clear code into the DAC register and loads it into the output.
- R7: Writing the software command address with data bit 1 set acts exactly like the `clr_n` falling edge.
- R8: `dev_reset_n` low, or a software command with data bit 2 set, restores the power-on state: DAC and clear registers 0, output code 0, `sdo` 0, control word 3'b011.
- R9: Control bit 2 selects two's-complement coding. The converter code is then the register value with its MSB inverted, and this applies to clear-code loads too. With bit 2 at 0, the code passes unchanged.
- R10: Control bit 1 is the output clamp and is 1 at power-on. While it is set, output loads still update `dac_code` but `dac_update` stays low. Control bit 0 is the buffer-mode flag and resets to 1.
- R11: `rst_n` resets the block asynchronously and is released synchronously to `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, data taken on its falling edge |
| sync_n | input | 1 | Active-low frame strobe |
| sdin | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (chain / readback) |
| ldac_n | input | 1 | Active-low load control |
| clr_n | input | 1 | Active-low clear, edge-triggered |
| dev_reset_n | input | 1 | Active-low functional reset pin |
| dac_code | output | 18 | Code presented to the converter core |
| dac_update | output | 1 | One-cycle pulse when a code is loaded, unclamped |

## Verification
The bench targets the framing edges. A 20-edge frame must leave the code and the readback untouched; a design that committed it would load a truncated value. A 48-edge frame must act on its last 24 bits; a design that kept the first 24 would break chaining. Readback is checked in the frame after the request, and the shift-out of a plain write is checked against the word sent before it. An off-by-one-frame `sdo` path would show up in both checks. The bench also covers the clamp after power-on and after a pin reset, where a missing suppression would emit strobes, and two's-complement clear loads, where applying the coding only to data writes would leave the MSB uninverted.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  typedef enum logic [2:0] {
    ADR_NONE  = 3'd0,
    ADR_DAC   = 3'd1,
    ADR_CTRL  = 3'd2,
    ADR_CLEAR = 3'd3,
    ADR_CMD   = 3'd4
  } sdac_addr_e;

  typedef struct packed {
    logic twos;   // bit 2: two's-complement coding
    logic clamp;  // bit 1: output clamp, strobe held off
    logic rbuf;   // bit 0: buffer-mode flag
  } sdac_ctrl_t;

  localparam sdac_ctrl_t CTRL_POR = '{twos: 1'b0, clamp: 1'b1, rbuf: 1'b1};

  localparam int CMD_CLEAR_BIT = 1;
  localparam int CMD_RESET_BIT = 2;

endpackage

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx #(
  parameter int FRAME_BITS = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  soft_rst,
  input  logic                  sclk,
  input  logic                  sync_n,
  input  logic                  sdin,
  input  logic                  ld_en,
  input  logic [FRAME_BITS-1:0] ld_word,
  output logic                  sdo,
  output logic                  frame_ok,
  output logic [FRAME_BITS-1:0] frame_word
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic                  sclk_q, sync_q;
  logic [FRAME_BITS-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  sclk_fall, sync_rise, sync_fall;

  assign sclk_fall  = sclk_q & ~sclk;
  assign sync_rise  = ~sync_q & sync_n;
  assign sync_fall  = sync_q & ~sync_n;
  assign frame_ok   = sync_rise & (cnt_q == CNT_FULL);
  assign frame_word = shreg_q;
  assign sdo        = shreg_q[FRAME_BITS-1];

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    if (soft_rst) begin
      shreg_d = '0;
      cnt_d   = '0;
    end else if (ld_en) begin
      shreg_d = ld_word;
    end else begin
      if (sync_fall) cnt_d = '0;
      if (!sync_n && sclk_fall) begin
        shreg_d = {shreg_q[FRAME_BITS-2:0], sdin};
        if (!sync_fall && cnt_q != CNT_FULL) cnt_d = cnt_q + 1'b1;
        else if (sync_fall) cnt_d = CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      sync_q  <= 1'b1;
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      sclk_q  <= sclk;
      sync_q  <= sync_n;
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_IDLE_SDO_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_n && sync_q && !ld_en && !soft_rst) |=> $stable(sdo)) else $error("idle sdo moved"); // R3

  AST_SOFT_RST_SDO: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (sdo == 1'b0)) else $error("sdo not cleared"); // R8

endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
#(
  parameter int FRAME_BITS = 24,
  parameter int CODE_W     = 18
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dev_reset_n,
  input  logic                  clr_n,
  input  logic                  frame_ok,
  input  logic [FRAME_BITS-1:0] frame_word,
  output logic                  soft_rst,
  output logic                  clr_evt,
  output logic                  dac_wr,
  output logic [CODE_W-1:0]     wr_code,
  output logic [CODE_W-1:0]     dac_reg,
  output logic [CODE_W-1:0]     clear_reg,
  output sdac_ctrl_t            ctrl,
  output logic                  rd_en,
  output logic [FRAME_BITS-1:0] rd_word
);
  localparam int DATA_W = FRAME_BITS - 4;
  localparam int PAD_W  = DATA_W - CODE_W;
  localparam int CTRL_W = $bits(sdac_ctrl_t);

  logic [DATA_W-1:0] data_f;
  sdac_addr_e        addr_f;
  logic              rd_f, wr_any, clr_q;
  logic [CODE_W-1:0] dac_d, clear_d;
  sdac_ctrl_t        ctrl_d;
  logic              pin_clr;

  assign rd_f    = frame_word[FRAME_BITS-1];
  assign addr_f  = sdac_addr_e'(frame_word[FRAME_BITS-2 -: 3]);
  assign data_f  = frame_word[DATA_W-1:0];
  assign wr_code = data_f[DATA_W-1 -: CODE_W];
  assign wr_any  = frame_ok & ~rd_f;
  assign rd_en   = frame_ok & rd_f;
  assign pin_clr = clr_q & ~clr_n;

  assign soft_rst = ~dev_reset_n | (wr_any & (addr_f == ADR_CMD) & data_f[CMD_RESET_BIT]);
  assign clr_evt  = ~soft_rst &
                    (pin_clr | (wr_any & (addr_f == ADR_CMD) & data_f[CMD_CLEAR_BIT]));
  assign dac_wr   = ~soft_rst & ~clr_evt & wr_any & (addr_f == ADR_DAC);

  always_comb begin
    dac_d   = dac_reg;
    clear_d = clear_reg;
    ctrl_d  = ctrl;
    if (soft_rst) begin
      dac_d   = '0;
      clear_d = '0;
      ctrl_d  = CTRL_POR;
    end else begin
      if (clr_evt) dac_d = clear_reg;
      else if (dac_wr) dac_d = wr_code;
      if (wr_any && addr_f == ADR_CLEAR) clear_d = wr_code;
      if (wr_any && addr_f == ADR_CTRL)  ctrl_d  = sdac_ctrl_t'(data_f[CTRL_W-1:0]);
    end
  end

  always_comb begin
    rd_word = {1'b1, 3'(addr_f), {DATA_W{1'b0}}};
    unique case (addr_f)
      ADR_DAC:   rd_word[DATA_W-1:0] = {dac_reg, {PAD_W{1'b0}}};
      ADR_CLEAR: rd_word[DATA_W-1:0] = {clear_reg, {PAD_W{1'b0}}};
      ADR_CTRL:  rd_word[DATA_W-1:0] = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
      default:   rd_word[DATA_W-1:0] = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_reg   <= '0;
      clear_reg <= '0;
      ctrl      <= CTRL_POR;
      clr_q     <= 1'b1;
    end else begin
      dac_reg   <= dac_d;
      clear_reg <= clear_d;
      ctrl      <= ctrl_d;
      clr_q     <= clr_n;
    end
  end

  AST_PIN_RESET_POR: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_reset_n |=> (ctrl == CTRL_POR && dac_reg == '0 && clear_reg == '0)) else $error("por"); // R8

  AST_CLR_PIN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && !clr_n && dev_reset_n) |=> (dac_reg == $past(clear_reg))) else $error("clr"); // R6

  AST_NO_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_ok && dev_reset_n) |=> ($stable(ctrl) && $stable(clear_reg))) else $error("hold"); // R2

endmodule

// File: rtl/sdac_out.sv
module sdac_out #(
  parameter int CODE_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              clr_evt,
  input  logic              dac_wr,
  input  logic              ldac_n,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [CODE_W-1:0] clear_code,
  input  logic [CODE_W-1:0] dac_reg,
  input  logic              twos,
  input  logic              clamp,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_update
);
  logic              ldac_q, ldac_fall, load;
  logic [CODE_W-1:0] src, code_d;
  logic              upd_d;

  function automatic logic [CODE_W-1:0] to_core(input logic [CODE_W-1:0] v, input logic tc);
    return tc ? {~v[CODE_W-1], v[CODE_W-2:0]} : v;
  endfunction

  assign ldac_fall = ldac_q & ~ldac_n;

  always_comb begin
    load = 1'b0;
    src  = dac_reg;
    if (clr_evt) begin
      load = 1'b1;
      src  = clear_code;
    end else if (dac_wr && !ldac_n) begin
      load = 1'b1;
      src  = wr_code;
    end else if (ldac_fall) begin
      load = 1'b1;
      src  = dac_reg;
    end
  end

  always_comb begin
    code_d = dac_code;
    upd_d  = 1'b0;
    if (soft_rst) begin
      code_d = '0;
    end else if (load) begin
      code_d = to_core(src, twos);
      upd_d  = ~clamp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code   <= '0;
      dac_update <= 1'b0;
      ldac_q     <= 1'b1;
    end else begin
      dac_code   <= code_d;
      dac_update <= upd_d;
      ldac_q     <= ldac_n;
    end
  end

  AST_CLAMP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    clamp |=> !dac_update) else $error("strobe while clamped"); // R10

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt && !dac_wr && !ldac_fall && !soft_rst) |=> $stable(dac_code)) else $error("code moved"); // R5

  AST_RESET_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (dac_code == '0 && !dac_update)) else $error("reset code"); // R8

endmodule

// File: rtl/sdac_port.sv
module sdac_port #(
  parameter int FRAME_BITS = 24,
  parameter int CODE_W     = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sync_n,
  input  logic              sdin,
  output logic              sdo,
  input  logic              ldac_n,
  input  logic              clr_n,
  input  logic              dev_reset_n,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_update
);
  import sdac_pkg::*;

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i = rst_sync_q[SYNC_STAGES-1];

  logic                  soft_rst, clr_evt, dac_wr, frame_ok, rd_en;
  logic [FRAME_BITS-1:0] frame_word, rd_word;
  logic [CODE_W-1:0]     wr_code, dac_reg, clear_reg;
  sdac_ctrl_t            ctrl;

  sdac_frame_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
    .clk(clk), .rst_n(rst_i), .soft_rst(soft_rst),
    .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
    .ld_en(rd_en), .ld_word(rd_word),
    .sdo(sdo), .frame_ok(frame_ok), .frame_word(frame_word)
  );

  sdac_regs #(.FRAME_BITS(FRAME_BITS), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_i), .dev_reset_n(dev_reset_n), .clr_n(clr_n),
    .frame_ok(frame_ok), .frame_word(frame_word),
    .soft_rst(soft_rst), .clr_evt(clr_evt), .dac_wr(dac_wr),
    .wr_code(wr_code), .dac_reg(dac_reg), .clear_reg(clear_reg),
    .ctrl(ctrl), .rd_en(rd_en), .rd_word(rd_word)
  );

  sdac_out #(.CODE_W(CODE_W)) u_out (
    .clk(clk), .rst_n(rst_i), .soft_rst(soft_rst), .clr_evt(clr_evt),
    .dac_wr(dac_wr), .ldac_n(ldac_n), .wr_code(wr_code),
    .clear_code(clear_reg), .dac_reg(dac_reg),
    .twos(ctrl.twos), .clamp(ctrl.clamp),
    .dac_code(dac_code), .dac_update(dac_update)
  );

  AST_RST_RELEASE_SYNC: assert property (@(posedge clk)
    $rose(rst_i) |-> $past(rst_n)) else $error("reset release"); // R11

endmodule

// File: tb/sdac_port_bench.sv
module sdac_port_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, sclk, sync_n, sdin, ldac_n, clr_n, dev_reset_n;
  logic        sdo, dac_update;
  logic [17:0] dac_code;

  int tests = 0;
  int fails = 0;
  int upd_cnt = 0;
  logic [23:0] cap;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdac_port u_sdac_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
    .sdo(sdo), .ldac_n(ldac_n), .clr_n(clr_n), .dev_reset_n(dev_reset_n),
    .dac_code(dac_code), .dac_update(dac_update)
  );

  always @(negedge clk) if (rst_n && dac_update) upd_cnt = upd_cnt + 1;

  function automatic logic [23:0] mk(input logic rd, input logic [2:0] a, input logic [19:0] d);
    return {rd, a, d};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [47:0] bits, input int n);
    cap = '0;
    @(negedge clk) sync_n = 1'b0;
    idle(2);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) begin sdin = bits[i]; sclk = 1'b1; end
      @(negedge clk);
      if (n - 1 - i < 24) cap = {cap[22:0], sdo};
      @(negedge clk) sclk = 1'b0;
    end
    @(negedge clk) sync_n = 1'b1;
    idle(3);
  endtask

  task automatic wr(input logic [2:0] a, input logic [19:0] d);
    xfer({24'h0, mk(1'b0, a, d)}, 24);
  endtask

  task automatic rd(input logic [2:0] a, output logic [23:0] val);
    xfer({24'h0, mk(1'b1, a, 20'h0)}, 24);
    xfer({24'h0, mk(1'b0, 3'd0, 20'h0)}, 24);
    val = cap;
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr_n = 1'b0;
    idle(2);
    @(negedge clk) clr_n = 1'b1;
    idle(2);
  endtask

  task automatic t_reset_state();
    logic [23:0] v;
    check("R11 code after reset", dac_code, 0);
    check("R11 strobe after reset", dac_update, 0);
    check("R3 sdo after reset", sdo, 0);
    xfer({24'h0, mk(1'b1, 3'd2, 20'h0)}, 24);
    check("R3 first frame shifts zeros", cap, 0);
    xfer({24'h0, mk(1'b0, 3'd0, 20'h0)}, 24);
    v = cap;
    check("R4 R8 R10 control readback 3'b011", v, 24'hA00003);
  endtask

  task automatic t_clamp_and_immediate();
    int u0;
    ldac_n = 1'b0;
    u0 = upd_cnt;
    wr(3'd1, 20'h12345 << 2);
    check("R10 clamped load updates code", dac_code, 18'h12345);
    check("R10 clamped load gives no strobe", upd_cnt - u0, 0);
    wr(3'd2, 20'h1);
    u0 = upd_cnt;
    wr(3'd1, 20'h2AAAA << 2);
    check("R5 immediate load code", dac_code, 18'h2AAAA);
    check("R5 R1 immediate load strobe", upd_cnt - u0, 1);
  endtask

  task automatic t_ldac_deferred();
    int u0;
    ldac_n = 1'b1;
    u0 = upd_cnt;
    wr(3'd1, 20'h00F0F << 2);
    check("R5 held while ldac_n high", dac_code, 18'h2AAAA);
    check("R5 no strobe while held", upd_cnt - u0, 0);
    @(negedge clk) ldac_n = 1'b0;
    idle(3);
    check("R5 ldac_n fall loads", dac_code, 18'h00F0F);
    check("R5 ldac_n fall strobe", upd_cnt - u0, 1);
  endtask

  task automatic t_short_frame();
    int u0;
    logic [23:0] v;
    u0 = upd_cnt;
    xfer({28'h0, mk(1'b0, 3'd1, 20'h3FFFF << 2) >> 4}, 20);
    check("R2 short frame leaves code", dac_code, 18'h00F0F);
    check("R2 short frame no strobe", upd_cnt - u0, 0);
    rd(3'd1, v);
    check("R2 R4 dac readback after short frame", v, 24'h903C3C);
  endtask

  task automatic t_daisy();
    int u0;
    wr(3'd5, 20'hABCDE);
    xfer({24'h0, 24'h0DEAD0}, 24);
    check("R3 sdo carries previous word", cap, 24'h5ABCDE);
    u0 = upd_cnt;
    xfer({24'h012345, mk(1'b0, 3'd1, 20'h1FFFF << 2)}, 48);
    check("R3 48-edge frame shifts previous word", cap, 24'h0DEAD0);
    check("R1 48-edge frame uses last 24 bits", dac_code, 18'h1FFFF);
    check("R1 48-edge frame strobe", upd_cnt - u0, 1);
  endtask

  task automatic t_clear();
    int u0;
    logic [23:0] v;
    wr(3'd3, 20'h00777 << 2);
    u0 = upd_cnt;
    pulse_clr();
    check("R6 clr_n loads clear code", dac_code, 18'h00777);
    check("R6 clr_n strobe", upd_cnt - u0, 1);
    rd(3'd1, v);
    check("R6 dac register holds clear code", v, 24'h901DDC);
    wr(3'd1, 20'h11111 << 2);
    check("R7 setup code", dac_code, 18'h11111);
    wr(3'd4, 20'h2);
    check("R7 software clear", dac_code, 18'h00777);
  endtask

  task automatic t_twos();
    wr(3'd2, 20'h5);
    wr(3'd1, 20'h00005 << 2);
    check("R9 twos data write", dac_code, 18'h20005);
    pulse_clr();
    check("R9 twos clear load", dac_code, 18'h20777);
  endtask

  task automatic t_resets();
    int u0;
    logic [23:0] v;
    @(negedge clk) dev_reset_n = 1'b0;
    idle(2);
    @(negedge clk) dev_reset_n = 1'b1;
    idle(2);
    check("R8 pin reset code", dac_code, 0);
    rd(3'd2, v);
    check("R8 pin reset control", v, 24'hA00003);
    u0 = upd_cnt;
    wr(3'd1, 20'h00100 << 2);
    check("R10 clamp back after reset", upd_cnt - u0, 0);
    wr(3'd3, 20'h3 << 2);
    wr(3'd4, 20'h4);
    check("R8 software reset code", dac_code, 0);
    rd(3'd3, v);
    check("R8 software reset clear register", v, 24'hB00000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; sync_n = 1'b1; sdin = 1'b0;
    ldac_n = 1'b1; clr_n = 1'b1; dev_reset_n = 1'b1;
    idle(4);
    @(negedge clk) rst_n = 1'b1;
    idle(4);
    t_reset_state();
    t_clamp_and_immediate();
    t_ldac_deferred();
    t_short_frame();
    t_daisy();
    t_clear();
    t_twos();
    t_resets();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule